// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is a single-master I2C controller. A host steers it with one-cycle command pulses. The commands are: open the bus with a Start, reopen it with a Repeated Start, send a byte, clock in a byte, answer a received byte with an acknowledge or a not-acknowledge, and close the bus with a Stop.

A down-counting baud generator sets every bus phase. A shift register moves the data, most significant bit first. A bus watcher reports whether a Start or a Stop was seen last. The controller drives the open-drain lines through active-high pull-low enables and reads the resolved line levels back.

Only one bus operation runs at a time, and nothing is queued. A command that arrives while an operation is in flight is dropped and flagged. A completed operation raises an interrupt flag, which the host clears. Multi-master arbitration is reduced to a single collision flag. Slave clock stretching is not supported.

The host issues Repeated Start, Stop, byte transfers and acknowledges only while it owns the bus, that is, after a Start, with SCL held low by the master. After a Stop completes, the host waits two clocks before it issues a new Start.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, both pull-low enables are 0. `busy`, `irq`, `wcol`, `bcol`, `start_seen` and `stop_seen` are all 0.
- R2: During byte transfers, every SCL high phase lasts `brg_reload`+1 clocks, and every SCL low phase inside a transfer also lasts `brg_reload`+1 clocks.
- R3: Start, accepted only when `start_seen` is 0, behaves as follows:
  - SDA is pulled low while SCL is released, for `brg_reload`+1 clocks.
  - SCL is then pulled low and `irq` is set.
  - `start_seen` then reads 1.
- R4: A buffer write behaves as follows:
  - It sends the 8 bits of `buf_wdata` MSB first, one bit per SCL pulse.
  - It releases SDA for a ninth pulse and stores the SDA level sampled there in `ack_stat` (0 = acknowledge).
  - It then sets `irq` and leaves SCL low.
- R5: A receive command clocks 8 bits with SDA released by the master. Each bit is sampled at the end of its SCL high phase, and the byte appears MSB first on `buf_rdata`, with `irq` set.
- R6: An acknowledge command produces one SCL pulse. During that pulse SDA is low when `ack_nack`=0 and released when `ack_nack`=1. `irq` is set at the end.
- R7: Stop behaves as follows:
  - SDA is pulled low with SCL low.
  - SCL is then released with SDA still low, for `brg_reload`+1 clocks.
  - SDA is then released and `irq` is set.
  - Afterwards `stop_seen`=1 and `start_seen`=0.
  - The two status bits are never 1 together.
- R8: Repeated Start behaves as follows:
  - SDA is released first, then SCL, then a normal Start sequence follows.
  - The bus therefore shows exactly one new Start, SDA is held low with SCL released for `brg_reload`+1 clocks, and `start_seen` reads 1.
- R9: A command or buffer write arriving while `busy` is 1 is discarded and sets `wcol`, and the operation in flight finishes unchanged. A Start while `start_seen`=1 is discarded and sets `wcol`.
- R10: If SDA reads low at the end of a data-bit high phase in which the master released it, the transfer is aborted:
  - `bcol` is set and `busy` drops.
  - SDA is released and SCL is held low.
  - `irq` is not set.
- R11: `flag_clr` clears `irq`, `wcol` and `bcol`. A flag set in the same cycle wins.
- R12: While `enable` is 0:
  - both lines are released within one clock and any operation is aborted;
  - `start_seen` and `stop_seen` are cleared;
  - commands are discarded without setting `wcol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; 0 releases the bus and clears bus status |
| brg_reload | input | 7 | Baud reload; each bus phase lasts reload+1 clocks |
| cmd_start | input | 1 | Pulse: issue Start |
| cmd_rstart | input | 1 | Pulse: issue Repeated Start |
| cmd_stop | input | 1 | Pulse: issue Stop |
| cmd_rcv | input | 1 | Pulse: receive one byte |
| cmd_ack | input | 1 | Pulse: send acknowledge bit |
| ack_nack | input | 1 | Level sent by cmd_ack (0 = ACK, 1 = NACK) |
| buf_wr | input | 1 | Pulse: load buf_wdata and transmit it |
| buf_wdata | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clears irq, wcol and bcol |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| buf_rdata | output | 8 | Last received byte |
| busy | output | 1 | A bus operation is in progress |
| start_seen | output | 1 | Last bus event was a Start |
| stop_seen | output | 1 | Last bus event was a Stop |
| ack_stat | output | 1 | Acknowledge level sampled after a transmitted byte |
| irq | output | 1 | Operation-complete flag |
| wcol | output | 1 | Discarded-command flag |
| bcol | output | 1 | Bus-collision flag |

## Verification
A sequencer stuck in the wrong phase shows at the line enables within one baud period. It stretches or shortens a measured SCL half-period, or it leaves `irq` unset so the wait for completion times out. A shift register that is loaded or rotated wrongly corrupts the captured bit string or `buf_rdata` of the very next byte. Every byte value is swept in both directions, so any stuck bit position appears. A bus watcher that is wrong shows up as a wrong `start_seen`/`stop_seen` pair two clocks after a Start or Stop completes, or as a Start that is refused with `wcol`.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_START,
        SEQ_RS_SDA,
        SEQ_RS_SCL,
        SEQ_STOP_LO,
        SEQ_STOP_SCL,
        SEQ_BIT_LO,
        SEQ_BIT_HI
    } seq_e;

    typedef enum logic [1:0] {
        OP_TX,
        OP_RX,
        OP_ACK
    } op_e;
endpackage

// File: rtl/i2cm_brg.sv
module i2cm_brg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == '0);
        if (!run || tick) cnt_d = reload;
        else              cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_seen,
    output logic stop_seen
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic s_flag;
        logic p_flag;
    } mon_t;

    mon_t d, q;
    logic fall_hi, rise_hi;

    always_comb begin
        d          = q;
        d.scl_prev = scl_in;
        d.sda_prev = sda_in;
        fall_hi    = q.scl_prev && scl_in && q.sda_prev && !sda_in;
        rise_hi    = q.scl_prev && scl_in && !q.sda_prev && sda_in;
        if (!enable) begin
            d.s_flag = 1'b0;
            d.p_flag = 1'b0;
        end else if (fall_hi) begin
            d.s_flag = 1'b1;
            d.p_flag = 1'b0;
        end else if (rise_hi) begin
            d.s_flag = 1'b0;
            d.p_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl_prev: 1'b1, sda_prev: 1'b1, s_flag: 1'b0, p_flag: 1'b0};
        else        q <= d;
    end

    assign start_seen = q.s_flag;
    assign stop_seen  = q.p_flag;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BRG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BRG_W-1:0]  brg_reload,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rcv,
    input  logic              cmd_ack,
    input  logic              ack_nack,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              flag_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              busy,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              ack_stat,
    output logic              irq,
    output logic              wcol,
    output logic              bcol
);
    localparam int BW = $clog2(DATA_W + 2);
    localparam logic [BW-1:0] LAST_DATA = BW'(DATA_W - 1);
    localparam logic [BW-1:0] ACK_SLOT  = BW'(DATA_W);

    typedef struct packed {
        seq_e              state;
        op_e               op;
        logic [DATA_W-1:0] shift;
        logic [BW-1:0]     bitn;
        logic              scl_low;
        logic              sda_low;
        logic [DATA_W-1:0] rd_data;
        logic              ack_stat;
        logic              irq;
        logic              wcol;
        logic              bcol;
    } ctrl_t;

    ctrl_t d, q;
    logic tick, run, cmd_any, last_slot;
    logic [BW-1:0] next_bit;

    assign run = enable && (q.state != SEQ_IDLE);

    i2cm_brg #(.W(BRG_W)) brg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (brg_reload),
        .tick   (tick)
    );

    i2cm_busmon mon_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    always_comb begin
        d         = q;
        cmd_any   = cmd_start | cmd_rstart | cmd_stop | cmd_rcv | cmd_ack | buf_wr;
        next_bit  = q.bitn + 1'b1;
        last_slot = ((q.op == OP_TX) && (q.bitn == ACK_SLOT)) ||
                    ((q.op == OP_RX) && (q.bitn == LAST_DATA)) ||
                    (q.op == OP_ACK);
        if (flag_clr) begin
            d.irq  = 1'b0;
            d.wcol = 1'b0;
            d.bcol = 1'b0;
        end
        if (!enable) begin
            d.state   = SEQ_IDLE;
            d.scl_low = 1'b0;
            d.sda_low = 1'b0;
        end else if (q.state != SEQ_IDLE) begin
            if (cmd_any) d.wcol = 1'b1;
            if (tick) begin
                case (q.state)
                    SEQ_START: begin
                        d.scl_low = 1'b1;
                        d.irq     = 1'b1;
                        d.state   = SEQ_IDLE;
                    end
                    SEQ_RS_SDA: begin
                        d.scl_low = 1'b0;
                        d.state   = SEQ_RS_SCL;
                    end
                    SEQ_RS_SCL: begin
                        d.sda_low = 1'b1;
                        d.state   = SEQ_START;
                    end
                    SEQ_STOP_LO: begin
                        d.scl_low = 1'b0;
                        d.state   = SEQ_STOP_SCL;
                    end
                    SEQ_STOP_SCL: begin
                        d.sda_low = 1'b0;
                        d.irq     = 1'b1;
                        d.state   = SEQ_IDLE;
                    end
                    SEQ_BIT_LO: begin
                        d.scl_low = 1'b0;
                        d.state   = SEQ_BIT_HI;
                    end
                    SEQ_BIT_HI: begin
                        if ((q.op == OP_TX) && (q.bitn < ACK_SLOT) && !q.sda_low && !sda_in) begin
                            d.bcol    = 1'b1;
                            d.scl_low = 1'b1;
                            d.sda_low = 1'b0;
                            d.state   = SEQ_IDLE;
                        end else begin
                            d.scl_low = 1'b1;
                            d.shift   = {q.shift[DATA_W-2:0], sda_in};
                            d.bitn    = next_bit;
                            if (last_slot) begin
                                d.state   = SEQ_IDLE;
                                d.irq     = 1'b1;
                                d.sda_low = 1'b0;
                                if (q.op == OP_TX) d.ack_stat = sda_in;
                                if (q.op == OP_RX) d.rd_data  = {q.shift[DATA_W-2:0], sda_in};
                            end else begin
                                d.state   = SEQ_BIT_LO;
                                d.sda_low = (q.op == OP_TX) && (next_bit < ACK_SLOT) &&
                                            !q.shift[DATA_W-2];
                            end
                        end
                    end
                    default: d.state = SEQ_IDLE;
                endcase
            end
        end else if (cmd_any) begin
            d.bitn = '0;
            if (cmd_start) begin
                if (start_seen) begin
                    d.wcol = 1'b1;
                end else begin
                    d.state   = SEQ_START;
                    d.sda_low = 1'b1;
                end
            end else if (cmd_rstart) begin
                d.state   = SEQ_RS_SDA;
                d.sda_low = 1'b0;
            end else if (cmd_stop) begin
                d.state   = SEQ_STOP_LO;
                d.sda_low = 1'b1;
            end else if (cmd_rcv) begin
                d.state   = SEQ_BIT_LO;
                d.op      = OP_RX;
                d.sda_low = 1'b0;
            end else if (cmd_ack) begin
                d.state   = SEQ_BIT_LO;
                d.op      = OP_ACK;
                d.sda_low = !ack_nack;
            end else begin
                d.state   = SEQ_BIT_LO;
                d.op      = OP_TX;
                d.shift   = buf_wdata;
                d.sda_low = !buf_wdata[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, op: OP_TX, default: '0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe    = q.scl_low;
    assign sda_oe    = q.sda_low;
    assign buf_rdata = q.rd_data;
    assign busy      = (q.state != SEQ_IDLE);
    assign ack_stat  = q.ack_stat;
    assign irq       = q.irq;
    assign wcol      = q.wcol;
    assign bcol      = q.bcol;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic busy,
    input logic cmd_start,
    input logic cmd_rstart,
    input logic cmd_stop,
    input logic cmd_rcv,
    input logic cmd_ack,
    input logic buf_wr,
    input logic flag_clr,
    input logic scl_oe,
    input logic sda_oe,
    input logic start_seen,
    input logic stop_seen,
    input logic irq,
    input logic wcol,
    input logic bcol
);
    logic cmd_any;
    assign cmd_any = cmd_start | cmd_rstart | cmd_stop | cmd_rcv | cmd_ack | buf_wr;

    assert_disable_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe && !start_seen && !stop_seen));

    assert_busy_cmd_wcol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && busy && cmd_any) |=> wcol);

    assert_status_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    assert_clr_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !busy) |=> !irq);

    assert_clr_bcol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !busy) |=> !bcol);

    assert_idle_disable_wcol_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && flag_clr) |=> !wcol);
endmodule

bind i2c_cmd_master i2cm_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .busy       (busy),
    .cmd_start  (cmd_start),
    .cmd_rstart (cmd_rstart),
    .cmd_stop   (cmd_stop),
    .cmd_rcv    (cmd_rcv),
    .cmd_ack    (cmd_ack),
    .buf_wr     (buf_wr),
    .flag_clr   (flag_clr),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .irq        (irq),
    .wcol       (wcol),
    .bcol       (bcol)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [6:0] brg_reload = '0;
    logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0;
    logic ack_nack = 0, buf_wr = 0, flag_clr = 0;
    logic [7:0] buf_wdata = '0;
    logic scl_in, sda_in, scl_oe, sda_oe;
    logic [7:0] buf_rdata;
    logic busy, start_seen, stop_seen, ack_stat, irq, wcol, bcol;

    int checks = 0;
    int errors = 0;

    // slave model: 0 idle, 1 acknowledger, 2 sender, 3 jam low
    int smode = 0;
    logic ack_en = 1'b0;
    logic [7:0] sbyte = '0;
    int fall_base = 0;
    int rise_base = 0;
    logic slave_low;

    // bus monitor state (single driver: the negedge monitor)
    int cyc = 0, rises = 0, falls = 0, t_rise = 0, t_fall = 0;
    int tim_bad = 0, starts = 0, stops = 0, slo_cnt = 0, rx_oe_cnt = 0;
    logic [8:0] cap = '0;
    logic pscl = 1'b1, psda = 1'b1;
    logic watch = 1'b0, rxw = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || slave_low);

    always_comb begin
        int idx;
        idx = falls - fall_base;
        case (smode)
            1: slave_low = ack_en && (idx == 8);
            2: slave_low = (idx >= 0) && (idx < 8) && !sbyte[7 - (idx & 7)];
            3: slave_low = 1'b1;
            default: slave_low = 1'b0;
        endcase
    end

    i2c_cmd_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .brg_reload(brg_reload),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_nack(ack_nack),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .flag_clr(flag_clr),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .buf_rdata(buf_rdata), .busy(busy), .start_seen(start_seen),
        .stop_seen(stop_seen), .ack_stat(ack_stat), .irq(irq), .wcol(wcol), .bcol(bcol)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!pscl && scl_in) begin
            cap <= {cap[7:0], sda_in};
            if (watch && (rises > rise_base) && (cyc - t_fall != int'(brg_reload) + 1))
                tim_bad <= tim_bad + 1;
            t_rise <= cyc;
            rises  <= rises + 1;
        end
        if (pscl && !scl_in) begin
            if (watch && (cyc - t_rise != int'(brg_reload) + 1)) tim_bad <= tim_bad + 1;
            t_fall <= cyc;
            falls  <= falls + 1;
        end
        if (pscl && scl_in && psda && !sda_in) starts <= starts + 1;
        if (pscl && scl_in && !psda && sda_in) stops <= stops + 1;
        if (sda_oe && !scl_oe) slo_cnt <= slo_cnt + 1;
        if (rxw && sda_oe) rx_oe_cnt <= rx_oe_cnt + 1;
        pscl <= scl_in;
        psda <= sda_in;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input int k);
        @(negedge clk);
        case (k)
            0: cmd_start = 1;
            1: cmd_rstart = 1;
            2: cmd_stop = 1;
            3: cmd_rcv = 1;
            4: cmd_ack = 1;
            5: buf_wr = 1;
            default: flag_clr = 1;
        endcase
        @(negedge clk);
        cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_rcv = 0;
        cmd_ack = 0; buf_wr = 0; flag_clr = 0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, req, int'(irq), 1);
        issue(6);
    endtask

    task automatic tx_byte(input logic [7:0] b, input logic ack);
        smode = 1; ack_en = ack; fall_base = falls; rise_base = rises;
        buf_wdata = b; watch = 1;
        issue(5);
        wait_irq("R4 tx irq");
        watch = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base, sbase;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe && !busy, "R1 lines/busy", int'({scl_oe, sda_oe, busy}), 0);
        check(!irq && !wcol && !bcol && !start_seen && !stop_seen, "R1 flags",
              int'({irq, wcol, bcol, start_seen, stop_seen}), 0);
        rst_n = 1;
        @(negedge clk);
        enable = 1;
        @(negedge clk);

        // R3 start at reload 0
        base = slo_cnt;
        issue(0);
        wait_irq("R3 start irq");
        check(slo_cnt - base == 1, "R3 sda-low hold", slo_cnt - base, 1);
        check(start_seen && !stop_seen, "R3 start_seen", int'({start_seen, stop_seen}), 2);
        check(scl_oe == 1'b1, "R3 scl held low", int'(scl_oe), 1);

        // R4 transmit sweep of all bytes
        for (int b = 0; b < 256; b++) begin
            tx_byte(8'(b), logic'(b[0]));
            check(cap[8:1] == 8'(b), "R4 tx bits", int'(cap[8:1]), b);
            check(ack_stat == !b[0], "R4 ack_stat", int'(ack_stat), int'(!b[0]));
        end
        check(rises - rise_base == 9, "R4 nine pulses", rises - rise_base, 9);

        // R5 receive sweep
        for (int b = 0; b < 256; b++) begin
            smode = 2; sbyte = 8'(b); fall_base = falls; rise_base = rises;
            watch = 1; rxw = 1;
            issue(3);
            wait_irq("R5 rx irq");
            watch = 0; rxw = 0;
            check(buf_rdata == 8'(b), "R5 rx data", int'(buf_rdata), b);
        end
        check(rx_oe_cnt == 0, "R5 sda released", rx_oe_cnt, 0);
        smode = 0;

        // R6 acknowledge command, both levels
        for (int a = 0; a < 2; a++) begin
            ack_nack = logic'(a);
            issue(4);
            wait_irq("R6 ack irq");
            check(cap[0] == logic'(a), "R6 ack level", int'(cap[0]), a);
        end

        // R2 timing at wider reloads
        for (int r = 1; r < 4; r++) begin
            brg_reload = 7'(r);
            tx_byte(8'h5A + 8'(r), 1'b1);
            check(cap[8:1] == 8'h5A + 8'(r), "R2 tx data at reload", int'(cap[8:1]), 'h5A + r);
        end
        check(tim_bad == 0, "R2 half periods", tim_bad, 0);

        // R8 repeated start at reload 2
        brg_reload = 7'd2;
        base = slo_cnt; sbase = starts;
        issue(1);
        wait_irq("R8 rstart irq");
        check(slo_cnt - base == 3, "R8 start hold", slo_cnt - base, 3);
        check(starts - sbase == 1, "R8 one start edge", starts - sbase, 1);
        check(start_seen == 1'b1, "R8 start_seen", int'(start_seen), 1);

        // R9 start refused while bus owned
        issue(0);
        @(negedge clk);
        check(wcol && !busy, "R9 start while owned", int'({wcol, busy}), 2);
        issue(6);
        check(!wcol && !irq, "R11 clear", int'({wcol, irq}), 0);

        // R9 buffer write while busy
        smode = 1; ack_en = 1; fall_base = falls; buf_wdata = 8'h3C;
        issue(5);
        repeat (3) @(negedge clk);
        buf_wdata = 8'hFF;
        issue(5);
        check(wcol == 1'b1, "R9 wcol on busy write", int'(wcol), 1);
        wait_irq("R9 irq");
        check(cap[8:1] == 8'h3C, "R9 byte unchanged", int'(cap[8:1]), 'h3C);

        // R11 set wins over clear
        @(negedge clk);
        cmd_rcv = 1; flag_clr = 1;
        @(negedge clk);
        cmd_rcv = 0; flag_clr = 0;
        @(negedge clk);
        buf_wr = 1; flag_clr = 1;
        @(negedge clk);
        buf_wr = 0; flag_clr = 0;
        check(wcol == 1'b1, "R11 set wins", int'(wcol), 1);
        smode = 0;
        wait_irq("R11 rx irq");
        issue(6);

        // R7 stop at reload 3
        brg_reload = 7'd3;
        base = slo_cnt; sbase = stops;
        issue(2);
        wait_irq("R7 stop irq");
        @(negedge clk);
        check(slo_cnt - base == 4, "R7 scl-first hold", slo_cnt - base, 4);
        check(stops - sbase == 1, "R7 stop edge", stops - sbase, 1);
        check(stop_seen && !start_seen, "R7 status", int'({stop_seen, start_seen}), 2);
        check(!scl_oe && !sda_oe, "R7 lines released", int'({scl_oe, sda_oe}), 0);

        // R10 bus collision
        brg_reload = 7'd1;
        issue(0);
        wait_irq("R10 start irq");
        smode = 3; buf_wdata = 8'hFF;
        issue(5);
        for (int n = 0; n < 100 && busy; n++) @(negedge clk);
        check(bcol && !busy && !irq, "R10 abort", int'({bcol, busy, irq}), 4);
        check(scl_oe && !sda_oe, "R10 lines", int'({scl_oe, sda_oe}), 2);
        issue(6);
        check(!bcol, "R11 clear bcol", int'(bcol), 0);
        smode = 0;
        issue(2);
        wait_irq("R10 stop irq");
        @(negedge clk);

        // R12 disable mid transfer
        issue(0);
        wait_irq("R12 start irq");
        smode = 1; fall_base = falls; buf_wdata = 8'hA5;
        issue(5);
        repeat (4) @(negedge clk);
        smode = 0;
        enable = 0;
        @(negedge clk);
        check(!scl_oe && !sda_oe && !busy, "R12 release", int'({scl_oe, sda_oe, busy}), 0);
        check(!start_seen && !stop_seen, "R12 status clear", int'({start_seen, stop_seen}), 0);
        issue(0);
        repeat (3) @(negedge clk);
        check(!sda_oe && !wcol && !busy, "R12 cmd discarded", int'({sda_oe, wcol, busy}), 0);
        enable = 1;
        @(negedge clk);
        issue(0);
        wait_irq("R12 restart irq");
        check(start_seen == 1'b1, "R12 restart", int'(start_seen), 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule